// File: doc/BRIEF.md
# Scanline Phase Sequencer with CPU Memory Lockout

This block times every scanline of a 160x144 tile-based LCD controller from a dot-clock enable. It runs a 456-dot line through three visible phases, object-attribute scan, pixel transfer and horizontal blank. It also counts lines from 0 to 153, with lines 144 to 153 held in vertical blank. From this position it builds a status byte and a line-compare flag, and it raises single-cycle interrupt request pulses for the start of vertical blank and for the start of horizontal blank.

The same phase decides which display memory belongs to the display and which to the CPU. While the display owns a memory, a CPU read of it returns 0xFF in place of the stored byte and a CPU write request to it never reaches the array. The memory arrays stay outside the block. The block passes the array's read data through to the CPU, or replaces it, and passes the CPU's write strobe on to the array, or suppresses it.

Top module: `lcd_phase_seq`

## Requirements
- R1: A synchronous active-high reset puts the sequencer at line 0, dot 0 in mode 2. The attribute-memory lock is set and the video-RAM lock is clear, the compare flag, both interrupt outputs and the status enable bits are 0, and the compare register is 0.
- R2: Each line has 456 dots (0..455). On lines 0..143, dots 0..79 are mode 2, dots 80..251 are mode 3 and dots 252..455 are mode 0. Mode 0 therefore first appears 252 enabled dots after the frame starts.
- R3: After dot 455 the line number `ly` goes up by one. Lines 144..153 are mode 1 for all dots. After line 153 `ly` wraps to 0 and the sequencer starts again in mode 2. `ly` never exceeds 153.
- R4: `stat[1:0]` holds the mode: 0 = horizontal blank, 1 = vertical blank, 2 = attribute scan, 3 = pixel transfer. `stat[2]` is the compare flag and `stat[6:3]` are software enable bits. `stat[3]` enables the horizontal-blank interrupt. `stat[7]` reads 0. A status write loads only bits 6:3, and bits 2:0 of the written value are ignored. Mode changes leave bits 6:2 untouched.
- R5: `oam_lock` is high exactly in mode 2 and `vram_lock` is high exactly in mode 3. Neither lock is high in modes 0 and 1.
- R6: While a memory is locked, its CPU read data is 0xFF. Otherwise it equals that memory's array read data.
- R7: While a memory is locked, its array write strobe is 0 whatever the CPU requests. Otherwise it follows the CPU write request.
- R8: `stat[2]` becomes 1 one clock after the sequencer sits at dot 0 of a visible line whose `ly` equals `lyc`. It becomes 0 one clock after any clock on which `ly` differs from `lyc`.
- R9: `irq_vblank` is a one-clock pulse. It is high in the clock right after the enabled dot that moves the sequencer from line 143 to line 144. That is 65664 enabled dots after frame start.
- R10: `irq_stat` is a one-clock pulse. It is high in the clock right after the enabled dot that enters mode 0 on a visible line, provided `stat[3]` was 1 on that dot.
- R11: Clocks with `dot_en` low change neither the line nor the dot position, and they raise no interrupt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| dot_en | input | 1 | Dot-clock enable, one dot per enabled clock |
| lyc_we | input | 1 | Load compare register |
| lyc_wdata | input | 8 | Compare register value |
| stat_we | input | 1 | Write status enable bits |
| stat_wdata | input | 8 | Status write value (bits 6:3 used) |
| vram_arr_rdata | input | 8 | Read data from the video RAM array |
| vram_cpu_we | input | 1 | CPU write request to video RAM |
| oam_arr_rdata | input | 8 | Read data from the attribute array |
| oam_cpu_we | input | 1 | CPU write request to attribute memory |
| ly | output | 8 | Current line number |
| lyc | output | 8 | Compare register |
| stat | output | 8 | Status byte |
| irq_vblank | output | 1 | Vertical-blank request pulse |
| irq_stat | output | 1 | Horizontal-blank status request pulse |
| vram_lock | output | 1 | Video RAM owned by the display |
| oam_lock | output | 1 | Attribute memory owned by the display |
| vram_cpu_rdata | output | 8 | Gated video RAM read data to the CPU |
| vram_arr_we | output | 1 | Gated video RAM write strobe |
| oam_cpu_rdata | output | 8 | Gated attribute read data to the CPU |
| oam_arr_we | output | 1 | Gated attribute write strobe |

## Verification
The line, dot, mode and both lock flags come from registers that move on the clock edge after an enabled dot. The gated read data and write strobes follow the locks and the CPU inputs in the same clock. The compare flag and both interrupt pulses come one clock after the dot that causes them. The bench keeps a behavioural position model that moves on the same edges. It drives inputs on the falling edge and samples everything just before that, so each result is compared in the clock where it is due. Spot checks pin mode 0 to enabled dot 252, the vertical-blank pulse to dot 65664 and the wrap to dot 70224. A later stretch runs with the enable held low on one clock in three.

// File: rtl/lcd_seq_pkg.sv
package lcd_seq_pkg;

    localparam int LY_W  = 8;
    localparam int DOT_W = 9;

    typedef enum logic [1:0] {
        MODE_HBLANK  = 2'd0,
        MODE_VBLANK  = 2'd1,
        MODE_OAMSCAN = 2'd2,
        MODE_XFER    = 2'd3
    } lcd_mode_e;

    typedef struct packed {
        logic [LY_W-1:0]  line;
        logic [DOT_W-1:0] dot;
    } line_pos_t;

    typedef struct packed {
        logic oam;
        logic vram;
    } lock_t;

    function automatic lcd_mode_e mode_of(line_pos_t p, int vis_lines,
                                          int scan_dots, int xfer_dots);
        lcd_mode_e m;
        if (int'(p.line) >= vis_lines)
            m = MODE_VBLANK;
        else if (int'(p.dot) < scan_dots)
            m = MODE_OAMSCAN;
        else if (int'(p.dot) < scan_dots + xfer_dots)
            m = MODE_XFER;
        else
            m = MODE_HBLANK;
        return m;
    endfunction

    function automatic lock_t lock_of(lcd_mode_e m);
        lock_t l;
        l.oam  = (m == MODE_OAMSCAN);
        l.vram = (m == MODE_XFER);
        return l;
    endfunction

endpackage

// File: rtl/lcd_line_timer.sv
module lcd_line_timer
    import lcd_seq_pkg::*;
#(
    parameter int DOTS_PER_LINE = 456,
    parameter int TOTAL_LINES   = 154
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      dot_en,
    output line_pos_t pos
);
    localparam logic [DOT_W-1:0] LAST_DOT  = DOT_W'(DOTS_PER_LINE - 1);
    localparam logic [LY_W-1:0]  LAST_LINE = LY_W'(TOTAL_LINES - 1);

    line_pos_t pos_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            pos_q <= '0;
        end else if (dot_en) begin
            if (pos_q.dot == LAST_DOT) begin
                pos_q.dot  <= '0;
                pos_q.line <= (pos_q.line == LAST_LINE) ? '0 : pos_q.line + 1'b1;
            end else begin
                pos_q.dot <= pos_q.dot + 1'b1;
            end
        end
    end

    assign pos = pos_q;
endmodule

// File: rtl/lcd_status_unit.sv
module lcd_status_unit
    import lcd_seq_pkg::*;
#(
    parameter int DOTS_PER_LINE = 456,
    parameter int VIS_LINES     = 144,
    parameter int HBLANK_DOT    = 252
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            dot_en,
    input  line_pos_t       pos,
    input  lcd_mode_e       mode,
    input  logic            lyc_we,
    input  logic [LY_W-1:0] lyc_wdata,
    input  logic            stat_we,
    input  logic [7:0]      stat_wdata,
    output logic [LY_W-1:0] lyc,
    output logic [7:0]      stat,
    output logic            irq_vblank,
    output logic            irq_stat
);
    localparam logic [DOT_W-1:0] LAST_DOT  = DOT_W'(DOTS_PER_LINE - 1);
    localparam logic [DOT_W-1:0] PRE_HBL   = DOT_W'(HBLANK_DOT - 1);
    localparam logic [LY_W-1:0]  LAST_VIS  = LY_W'(VIS_LINES - 1);
    localparam logic [LY_W-1:0]  VIS_COUNT = LY_W'(VIS_LINES);

    logic [LY_W-1:0] lyc_q;
    logic [3:0]      enables_q;
    logic            coin_q;
    logic            vbl_q;
    logic            hbl_q;
    logic            visible;

    assign visible = (pos.line < VIS_COUNT);

    always_ff @(posedge clk) begin
        if (rst) begin
            lyc_q     <= '0;
            enables_q <= '0;
            coin_q    <= 1'b0;
            vbl_q     <= 1'b0;
            hbl_q     <= 1'b0;
        end else begin
            if (lyc_we)
                lyc_q <= lyc_wdata;
            if (stat_we)
                enables_q <= stat_wdata[6:3];
            if (pos.line != lyc_q)
                coin_q <= 1'b0;
            else if (pos.dot == '0 && visible)
                coin_q <= 1'b1;
            vbl_q <= dot_en && pos.line == LAST_VIS && pos.dot == LAST_DOT;
            hbl_q <= dot_en && visible && pos.dot == PRE_HBL && enables_q[0];
        end
    end

    assign lyc        = lyc_q;
    assign stat       = {1'b0, enables_q, coin_q, mode};
    assign irq_vblank = vbl_q;
    assign irq_stat   = hbl_q;
endmodule

// File: rtl/lcd_mem_gate.sv
module lcd_mem_gate #(
    parameter int DW = 8
) (
    input  logic          lock,
    input  logic [DW-1:0] arr_rdata,
    input  logic          cpu_we,
    output logic [DW-1:0] cpu_rdata,
    output logic          arr_we
);
    always_comb begin
        cpu_rdata = lock ? {DW{1'b1}} : arr_rdata;
        arr_we    = cpu_we && !lock;
    end
endmodule

// File: rtl/lcd_phase_seq.sv
module lcd_phase_seq
    import lcd_seq_pkg::*;
#(
    parameter int DOTS_PER_LINE = 456,
    parameter int SCAN_DOTS     = 80,
    parameter int XFER_DOTS     = 172,
    parameter int VIS_LINES     = 144,
    parameter int TOTAL_LINES   = 154,
    parameter int DW            = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          dot_en,
    input  logic          lyc_we,
    input  logic [7:0]    lyc_wdata,
    input  logic          stat_we,
    input  logic [7:0]    stat_wdata,
    input  logic [DW-1:0] vram_arr_rdata,
    input  logic          vram_cpu_we,
    input  logic [DW-1:0] oam_arr_rdata,
    input  logic          oam_cpu_we,
    output logic [7:0]    ly,
    output logic [7:0]    lyc,
    output logic [7:0]    stat,
    output logic          irq_vblank,
    output logic          irq_stat,
    output logic          vram_lock,
    output logic          oam_lock,
    output logic [DW-1:0] vram_cpu_rdata,
    output logic          vram_arr_we,
    output logic [DW-1:0] oam_cpu_rdata,
    output logic          oam_arr_we
);
    localparam int HBLANK_DOT = SCAN_DOTS + XFER_DOTS;
    localparam int NMEM       = 2;

    line_pos_t pos;
    lcd_mode_e mode;
    lock_t     locks;

    logic [NMEM-1:0]         g_lock;
    logic [NMEM-1:0][DW-1:0] g_arr_rd;
    logic [NMEM-1:0]         g_cpu_we;
    logic [NMEM-1:0][DW-1:0] g_cpu_rd;
    logic [NMEM-1:0]         g_arr_we;

    lcd_line_timer #(
        .DOTS_PER_LINE(DOTS_PER_LINE),
        .TOTAL_LINES  (TOTAL_LINES)
    ) u_timer (
        .clk   (clk),
        .rst   (rst),
        .dot_en(dot_en),
        .pos   (pos)
    );

    assign mode  = mode_of(pos, VIS_LINES, SCAN_DOTS, XFER_DOTS);
    assign locks = lock_of(mode);

    lcd_status_unit #(
        .DOTS_PER_LINE(DOTS_PER_LINE),
        .VIS_LINES    (VIS_LINES),
        .HBLANK_DOT   (HBLANK_DOT)
    ) u_status (
        .clk       (clk),
        .rst       (rst),
        .dot_en    (dot_en),
        .pos       (pos),
        .mode      (mode),
        .lyc_we    (lyc_we),
        .lyc_wdata (lyc_wdata),
        .stat_we   (stat_we),
        .stat_wdata(stat_wdata),
        .lyc       (lyc),
        .stat      (stat),
        .irq_vblank(irq_vblank),
        .irq_stat  (irq_stat)
    );

    assign g_lock   = {locks.oam, locks.vram};
    assign g_arr_rd = {oam_arr_rdata, vram_arr_rdata};
    assign g_cpu_we = {oam_cpu_we, vram_cpu_we};

    for (genvar g = 0; g < NMEM; g++) begin : g_gate
        lcd_mem_gate #(.DW(DW)) u_gate (
            .lock     (g_lock[g]),
            .arr_rdata(g_arr_rd[g]),
            .cpu_we   (g_cpu_we[g]),
            .cpu_rdata(g_cpu_rd[g]),
            .arr_we   (g_arr_we[g])
        );
    end

    assign vram_cpu_rdata = g_cpu_rd[0];
    assign vram_arr_we    = g_arr_we[0];
    assign oam_cpu_rdata  = g_cpu_rd[1];
    assign oam_arr_we     = g_arr_we[1];
    assign vram_lock      = locks.vram;
    assign oam_lock       = locks.oam;
    assign ly             = pos.line;
endmodule

// File: rtl/lcd_phase_seq_chk.sv
module lcd_phase_seq_chk #(
    parameter int TOTAL_LINES = 154,
    parameter int VIS_LINES   = 144,
    parameter int DW          = 8
) (
    input logic          clk,
    input logic          rst,
    input logic          dot_en,
    input logic [7:0]    ly,
    input logic [7:0]    stat,
    input logic          irq_vblank,
    input logic          irq_stat,
    input logic          vram_lock,
    input logic          oam_lock,
    input logic [DW-1:0] vram_cpu_rdata,
    input logic          vram_arr_we,
    input logic [DW-1:0] oam_cpu_rdata,
    input logic          oam_arr_we
);
    AST_LOCK_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
        !(vram_lock && oam_lock)); // R5
    AST_VRAM_LOCK_MODE: assert property (@(posedge clk) disable iff (rst)
        vram_lock |-> stat[1:0] == 2'd3); // R5
    AST_OAM_LOCK_MODE: assert property (@(posedge clk) disable iff (rst)
        oam_lock |-> stat[1:0] == 2'd2); // R5
    AST_VRAM_READ_FLOAT: assert property (@(posedge clk) disable iff (rst)
        vram_lock |-> vram_cpu_rdata == {DW{1'b1}}); // R6
    AST_OAM_READ_FLOAT: assert property (@(posedge clk) disable iff (rst)
        oam_lock |-> oam_cpu_rdata == {DW{1'b1}}); // R6
    AST_VRAM_WRITE_DROP: assert property (@(posedge clk) disable iff (rst)
        vram_lock |-> !vram_arr_we); // R7
    AST_OAM_WRITE_DROP: assert property (@(posedge clk) disable iff (rst)
        oam_lock |-> !oam_arr_we); // R7
    AST_LY_RANGE: assert property (@(posedge clk) disable iff (rst)
        int'(ly) < TOTAL_LINES); // R3
    AST_VBLANK_PULSE: assert property (@(posedge clk) disable iff (rst)
        irq_vblank |=> !irq_vblank); // R9
    AST_VBLANK_ENTRY: assert property (@(posedge clk) disable iff (rst)
        irq_vblank |-> (int'(ly) == VIS_LINES && stat[1:0] == 2'd1)); // R9
    AST_STAT_IRQ_HBLANK: assert property (@(posedge clk) disable iff (rst)
        irq_stat |-> stat[1:0] == 2'd0); // R10
    AST_STAT_PULSE: assert property (@(posedge clk) disable iff (rst)
        irq_stat |=> !irq_stat); // R10
    AST_FREEZE_LINE: assert property (@(posedge clk) disable iff (rst)
        !dot_en |=> $stable(ly)); // R11
endmodule

bind lcd_phase_seq lcd_phase_seq_chk #(
    .TOTAL_LINES(TOTAL_LINES),
    .VIS_LINES  (VIS_LINES),
    .DW         (DW)
) u_chk (
    .clk           (clk),
    .rst           (rst),
    .dot_en        (dot_en),
    .ly            (ly),
    .stat          (stat),
    .irq_vblank    (irq_vblank),
    .irq_stat      (irq_stat),
    .vram_lock     (vram_lock),
    .oam_lock      (oam_lock),
    .vram_cpu_rdata(vram_cpu_rdata),
    .vram_arr_we   (vram_arr_we),
    .oam_cpu_rdata (oam_cpu_rdata),
    .oam_arr_we    (oam_arr_we)
);

// File: tb/lcd_phase_seq_tb.sv
module lcd_phase_seq_tb;
    localparam int CLK_PERIOD = 10;
    localparam int END_CYC    = 74000;
    localparam int WATCHDOG   = 90000;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       dot_en = 1'b0;
    logic       lyc_we = 1'b0;
    logic [7:0] lyc_wdata = '0;
    logic       stat_we = 1'b0;
    logic [7:0] stat_wdata = '0;
    logic [7:0] vram_arr_rdata = '0;
    logic       vram_cpu_we = 1'b0;
    logic [7:0] oam_arr_rdata = '0;
    logic       oam_cpu_we = 1'b0;
    logic [7:0] ly, lyc, stat, vram_cpu_rdata, oam_cpu_rdata;
    logic       irq_vblank, irq_stat, vram_lock, oam_lock, vram_arr_we, oam_arr_we;

    lcd_phase_seq u_dut (
        .clk(clk), .rst(rst), .dot_en(dot_en),
        .lyc_we(lyc_we), .lyc_wdata(lyc_wdata),
        .stat_we(stat_we), .stat_wdata(stat_wdata),
        .vram_arr_rdata(vram_arr_rdata), .vram_cpu_we(vram_cpu_we),
        .oam_arr_rdata(oam_arr_rdata), .oam_cpu_we(oam_cpu_we),
        .ly(ly), .lyc(lyc), .stat(stat),
        .irq_vblank(irq_vblank), .irq_stat(irq_stat),
        .vram_lock(vram_lock), .oam_lock(oam_lock),
        .vram_cpu_rdata(vram_cpu_rdata), .vram_arr_we(vram_arr_we),
        .oam_cpu_rdata(oam_cpu_rdata), .oam_arr_we(oam_arr_we)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int checks = 0;
    int errors = 0;
    int cyc    = 0;
    int total  = 0;
    bit done   = 1'b0;

    // behavioural reference state
    int       m_line = 0;
    int       m_dot  = 0;
    bit [7:0] m_lyc  = '0;
    bit [3:0] m_en   = '0;
    bit       m_coin = 1'b0;
    bit       m_iv   = 1'b0;
    bit       m_is   = 1'b0;

    function automatic int exp_mode(int line, int dot);
        if (line >= 144) return 1;
        if (dot < 80)    return 2;
        if (dot < 252)   return 3;
        return 0;
    endfunction

    task automatic chk(bit ok, string tag, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s at cycle %0d: actual %0h expected %0h", tag, cyc, act, exp);
        end
    endtask

    always @(posedge clk) begin
        total <= total + 1;
        if (rst) begin
            m_line <= 0; m_dot <= 0; m_lyc <= '0; m_en <= '0;
            m_coin <= 1'b0; m_iv <= 1'b0; m_is <= 1'b0; cyc <= 0;
        end else begin
            cyc <= cyc + 1;
            if (lyc_we)  m_lyc <= lyc_wdata;
            if (stat_we) m_en  <= stat_wdata[6:3];
            if (m_line != int'(m_lyc))             m_coin <= 1'b0;
            else if (m_dot == 0 && m_line < 144)   m_coin <= 1'b1;
            m_iv <= dot_en && m_line == 143 && m_dot == 455;
            m_is <= dot_en && m_line < 144 && m_dot == 251 && m_en[0];
            if (dot_en) begin
                if (m_dot == 455) begin
                    m_dot  <= 0;
                    m_line <= (m_line == 153) ? 0 : m_line + 1;
                end else begin
                    m_dot <= m_dot + 1;
                end
            end
        end
    end

    // compare, then drive the next inputs
    always @(negedge clk) begin
        int em;
        int ev, eo;
        if (total > 0 && !done) begin
            em = exp_mode(m_line, m_dot);
            if (rst) begin
                chk(ly == 8'd0 && stat == 8'h02 && oam_lock && !vram_lock
                    && !irq_vblank && !irq_stat && lyc == 8'd0, "R1 reset state",
                    {ly, stat}, 32'h0002);
            end else begin
                chk(int'(ly) == m_line, "R3 line number", ly, m_line);
                chk(int'(stat[1:0]) == em, "R2 mode field", stat[1:0], em);
                chk(stat[7:3] == {1'b0, m_en}, "R4 enable bits", stat[7:3], {1'b0, m_en});
                chk(stat[2] == m_coin, "R8 compare flag", stat[2], m_coin);
                chk(oam_lock == (em == 2) && vram_lock == (em == 3), "R5 locks",
                    {oam_lock, vram_lock}, {em == 2, em == 3});
                ev = (em == 3) ? 8'hFF : vram_arr_rdata;
                eo = (em == 2) ? 8'hFF : oam_arr_rdata;
                chk(int'(vram_cpu_rdata) == ev, "R6 video RAM read", vram_cpu_rdata, ev);
                chk(int'(oam_cpu_rdata) == eo, "R6 attribute read", oam_cpu_rdata, eo);
                chk(vram_arr_we == (vram_cpu_we && em != 3), "R7 video RAM write",
                    vram_arr_we, vram_cpu_we && em != 3);
                chk(oam_arr_we == (oam_cpu_we && em != 2), "R7 attribute write",
                    oam_arr_we, oam_cpu_we && em != 2);
                chk(irq_vblank == m_iv, "R9 vblank pulse", irq_vblank, m_iv);
                chk(irq_stat == m_is, "R10 status pulse", irq_stat, m_is);
                if (cyc == 251) chk(stat[1:0] == 2'd3, "R2 last transfer dot", stat[1:0], 3);
                if (cyc == 252) chk(stat[1:0] == 2'd0, "R2 hblank at 252", stat[1:0], 0);
                if (cyc == 252) chk(irq_stat, "R10 first hblank request", irq_stat, 1);
                if (cyc == 65664) chk(irq_vblank && ly == 8'd144, "R9 vblank at 65664",
                                      {irq_vblank, ly}, {1'b1, 8'd144});
                if (cyc == 70223) chk(ly == 8'd153, "R3 last line", ly, 153);
                if (cyc == 70224) chk(ly == 8'd0 && stat[1:0] == 2'd2, "R3 wrap to line 0",
                                      {ly, stat[1:0]}, {8'd0, 2'd2});
            end
        end
        if (!rst && !done) begin
            // R11: from cycle 71000 the enable drops on one clock in three
            dot_en         = (cyc < 71000) ? 1'b1 : ((cyc % 3) != 0);
            vram_arr_rdata = 8'($urandom);
            oam_arr_rdata  = 8'($urandom);
            vram_cpu_we    = $urandom % 2;
            oam_cpu_we     = $urandom % 2;
            stat_we        = (cyc == 0 || cyc == 30000 || cyc == 71500);
            stat_wdata     = (cyc == 0) ? 8'h0F : (cyc == 30000) ? 8'h77 : 8'hCB;
            lyc_we         = (cyc == 0 || cyc == 71200);
            lyc_wdata      = (cyc == 0) ? 8'd5 : 8'd3;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        while (cyc < END_CYC && total < WATCHDOG) @(posedge clk);
        if (total >= WATCHDOG) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired at cycle %0d: actual %0d expected %0d", cyc, total, END_CYC);
        end
        @(negedge clk);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule